// File: doc/BRIEF.md
# Flash Row Program/Erase Controller

This controller sits between a CPU register port and a byte-wide flash array model. Software loads a bank of byte holding latches one byte at a time. Each latch write goes to the latch picked by the low pointer bits. A write never goes to the flash directly. A whole row is then erased or programmed in one operation.

Before the operation starts, software sets up the control register. It then writes two key bytes to the key register, and the very next accepted write sets the start bit. While the operation runs, the CPU port is stalled. The controller walks the row one byte per cycle through the flash port, then waits out a parameterised operation timer, and then reports completion.

Programming only clears bits: each flash byte becomes its old value ANDed with its latch. A latch left at FFh therefore leaves its byte untouched, and a partial-row update is possible. An erase fills the row with FFh. If the target is protected or invalid, the operation aborts with an error flag and the flash is not touched.

Top module: `frow_ctrl`

## Requirements
- R1: A write to register select 2 stores the data byte in the latch indexed by pointer bits [LAT_W-1:0]. It does no protection check, and it does not change the done or error flags.
- R2: All latches hold FFh after reset and after each completed program operation. A program with no latches loaded leaves the row unchanged.
- R3: A program writes every byte of the addressed row (pointer bits above LAT_W) with the old flash value ANDed with its latch. Bytes whose latch is FFh keep their value.
- R4: An erase (control bit 2 set, memory select bits [1:0] = 2'b10) writes FFh to every byte of the addressed row.
- R5: A control write with start (bit 4) set starts an operation only when all three of these hold: write-enable (bit 3) is set in that write; the two previous accepted writes were 55h then AAh to key register select 4; and nothing else came between them. In every other case the start is ignored: no busy, no flash write, start reads 0.
- R6: A start is rejected if any of these holds: the row base is below PROT_BYTES, the row base is at or above FLASH_BYTES, or memory select is not 2'b10. On rejection the start bit stays 0, there is no flash write, err_flag is set, and busy stays low.
- R7: busy is high, and cmd_ready low, for exactly BLOCK + OP_CYCLES cycles, starting the cycle after the start write is accepted. Writes offered in that time are held until ready returns.
- R8: On completion the start bit clears and done_flag sets. The write-enable bit keeps its value. irq equals done_flag AND the interrupt enable (select 5, bit 0).
- R9: A write to select 6 clears done_flag when bit 0 is set, and err_flag when bit 1 is set.
- R10: After reset, busy, the start, write-enable and erase bits, done_flag, err_flag and irq are 0, and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Register write offered |
| cmd_ready | output | 1 | Write accepted when high with cmd_valid; low while busy |
| cmd_sel | input | 3 | Register select: 0 ptr low, 1 ptr high, 2 latch, 3 control, 4 key, 5 irq enable, 6 flag clear |
| cmd_data | input | 8 | Write data |
| busy | output | 1 | CPU stall, operation in progress |
| ctrl_msel | output | 2 | Memory select field |
| ctrl_erase | output | 1 | Erase-select bit |
| ctrl_wen | output | 1 | Write-enable bit |
| ctrl_start | output | 1 | Start bit |
| done_flag | output | 1 | Completion flag |
| err_flag | output | 1 | Write-error flag |
| irq | output | 1 | Completion interrupt |
| fl_we | output | 1 | Flash byte write strobe |
| fl_addr | output | ADDR_W | Flash byte address, also the read address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data for fl_addr, combinational |

## Verification
Register writes take effect on the edge that accepts them. The bench's write task returns at the falling edge after that acceptance, so start, error, flag and irq results are sampled there, one register stage later. Flash writes begin on the cycle after an accepted start, with one byte per cycle. Each one is compared at the falling edge against a queue of expected address/data pairs, which the bench loads from its own row model before it issues the start. Busy is counted falling edge by falling edge until it drops, and the count must equal BLOCK + OP_CYCLES. The done, start-clear and latch-reset results are sampled at the first falling edge with busy low.

// File: rtl/frow_pkg.sv
package frow_pkg;
  typedef enum logic [2:0] {
    SEL_PTR_LO = 3'd0,
    SEL_PTR_HI = 3'd1,
    SEL_LATCH  = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_KEY    = 3'd4,
    SEL_IE     = 3'd5,
    SEL_CLR    = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WALK, SQ_WAIT} seq_st_e;
  typedef enum logic [1:0] {UK_IDLE, UK_ONE, UK_ARMED} key_st_e;

  localparam logic [1:0] MSEL_PROG = 2'b10;
  localparam int CB_ERASE = 2;
  localparam int CB_WEN   = 3;
  localparam int CB_START = 4;
endpackage

// File: rtl/frow_latch_bank.sv
module frow_latch_bank #(
  parameter int BLOCK = 8,
  parameter int LAT_W = $clog2(BLOCK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             clr_all,
  input  logic [LAT_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] hold_q [BLOCK];

  for (genvar g = 0; g < BLOCK; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  hold_q[g] <= 8'hFF;
      else if (clr_all)                            hold_q[g] <= 8'hFF;
      else if (wr_en && wr_idx == LAT_W'(g))       hold_q[g] <= wr_data;
    end
  end

  assign rd_data = hold_q[rd_idx];
endmodule

// File: rtl/frow_unlock.sv
module frow_unlock
  import frow_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'h55,
  parameter logic [7:0] KEY2 = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [2:0] sel,
  input  logic [7:0] data,
  output logic       armed
);
  key_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UK_IDLE;
    else if (acc) begin
      if (sel == SEL_KEY && data == KEY1)                       st_q <= UK_ONE;
      else if (st_q == UK_ONE && sel == SEL_KEY && data == KEY2) st_q <= UK_ARMED;
      else                                                       st_q <= UK_IDLE;
    end
  end

  assign armed = (st_q == UK_ARMED);
endmodule

// File: rtl/frow_seq.sv
module frow_seq
  import frow_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BLOCK     = 8,
  parameter int OP_CYCLES = 250000,
  parameter int LAT_W     = $clog2(BLOCK),
  parameter int ROW_W     = ADDR_W - LAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ROW_W-1:0]  go_row,
  input  logic              go_erase,
  input  logic [7:0]        fl_rdata,
  input  logic [7:0]        lat_data,
  output logic [LAT_W-1:0]  lat_idx,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              busy,
  output logic              op_end,
  output logic              erase_q
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);

  seq_st_e          st_q;
  logic [ROW_W-1:0] row_q;
  logic [LAT_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      row_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      erase_q <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (go) begin
          st_q    <= SQ_WALK;
          row_q   <= go_row;
          erase_q <= go_erase;
          idx_q   <= '0;
        end
        SQ_WALK: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAT_W'(BLOCK - 1)) begin
            st_q  <= SQ_WAIT;
            cnt_q <= '0;
          end
        end
        SQ_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OP_CYCLES - 1)) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign fl_we    = (st_q == SQ_WALK);
  assign lat_idx  = idx_q;
  assign fl_addr  = {row_q, idx_q};
  assign fl_wdata = erase_q ? 8'hFF : (fl_rdata & lat_data);
  assign op_end   = (st_q == SQ_WAIT) && (cnt_q == CNT_W'(OP_CYCLES - 1));
endmodule

// File: rtl/frow_ctrl.sv
module frow_ctrl
  import frow_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         BLOCK       = 8,
  parameter int         FLASH_BYTES = 3072,
  parameter int         PROT_BYTES  = 256,
  parameter int         OP_CYCLES   = 250000,
  parameter logic [7:0] KEY1        = 8'h55,
  parameter logic [7:0] KEY2        = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_sel,
  input  logic [7:0]        cmd_data,
  output logic              busy,
  output logic [1:0]        ctrl_msel,
  output logic              ctrl_erase,
  output logic              ctrl_wen,
  output logic              ctrl_start,
  output logic              done_flag,
  output logic              err_flag,
  output logic              irq,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata
);
  localparam int LAT_W = $clog2(BLOCK);
  localparam int ROW_W = ADDR_W - LAT_W;

  logic [ADDR_W-1:0] ptr_q;
  logic              ie_q;
  logic              acc, armed, try_start, bad, go, op_end, erase_q;
  logic [ADDR_W-1:0] base;
  logic [LAT_W-1:0]  lat_idx;
  logic [7:0]        lat_data;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign base      = {ptr_q[ADDR_W-1:LAT_W], {LAT_W{1'b0}}};
  assign try_start = acc && (cmd_sel == SEL_CTRL) && cmd_data[CB_START]
                     && cmd_data[CB_WEN] && armed;
  assign bad       = (cmd_data[1:0] != MSEL_PROG) || (int'(base) < PROT_BYTES)
                     || (int'(base) >= FLASH_BYTES);
  assign go        = try_start && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      ie_q       <= 1'b0;
      ctrl_msel  <= 2'b00;
      ctrl_erase <= 1'b0;
      ctrl_wen   <= 1'b0;
      ctrl_start <= 1'b0;
      done_flag  <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (acc) begin
        unique case (cmd_sel)
          SEL_PTR_LO: ptr_q[7:0]        <= cmd_data;
          SEL_PTR_HI: ptr_q[ADDR_W-1:8] <= cmd_data[ADDR_W-9:0];
          SEL_CTRL: begin
            ctrl_msel  <= cmd_data[1:0];
            ctrl_erase <= cmd_data[CB_ERASE];
            ctrl_wen   <= cmd_data[CB_WEN];
            ctrl_start <= go;
          end
          SEL_IE: ie_q <= cmd_data[0];
          SEL_CLR: begin
            if (cmd_data[0]) done_flag <= 1'b0;
            if (cmd_data[1]) err_flag  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (try_start && bad) err_flag <= 1'b1;
      if (op_end) begin
        ctrl_start <= 1'b0;
        done_flag  <= 1'b1;
      end
    end
  end

  assign irq = done_flag && ie_q;

  frow_unlock #(.KEY1(KEY1), .KEY2(KEY2)) unlock_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel(cmd_sel), .data(cmd_data), .armed(armed)
  );

  frow_latch_bank #(.BLOCK(BLOCK)) latch_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && cmd_sel == SEL_LATCH), .wr_idx(ptr_q[LAT_W-1:0]), .wr_data(cmd_data),
    .clr_all(op_end && !erase_q), .rd_idx(lat_idx), .rd_data(lat_data)
  );

  frow_seq #(.ADDR_W(ADDR_W), .BLOCK(BLOCK), .OP_CYCLES(OP_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_row(ptr_q[ADDR_W-1:LAT_W]),
    .go_erase(cmd_data[CB_ERASE]), .fl_rdata(fl_rdata), .lat_data(lat_data),
    .lat_idx(lat_idx), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .busy(busy), .op_end(op_end), .erase_q(erase_q)
  );
endmodule

// File: rtl/frow_ctrl_chk.sv
module frow_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ctrl_erase,
  input logic       ctrl_wen,
  input logic       ctrl_start,
  input logic       done_flag,
  input logic       err_flag,
  input logic       irq,
  input logic       fl_we,
  input logic [7:0] fl_wdata,
  input logic [7:0] fl_rdata
);
  assert_we_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> busy);
  assert_busy_has_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ctrl_start);
  assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && ctrl_erase) |-> fl_wdata == 8'hFF);
  assert_prog_clears_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !ctrl_erase) |-> (fl_wdata & ~fl_rdata) == 8'h00);
  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_flag && !ctrl_start));
  assert_wen_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(ctrl_wen));
  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);
  assert_err_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !busy);
endmodule

bind frow_ctrl frow_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctrl_erase(ctrl_erase), .ctrl_wen(ctrl_wen),
  .ctrl_start(ctrl_start), .done_flag(done_flag), .err_flag(err_flag), .irq(irq),
  .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
);

// File: tb/frow_ctrl_tb_top.sv
module frow_ctrl_tb_top;
  localparam int AW = 12;
  localparam int BLK = 8;
  localparam int OPC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_sel = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, busy, ctrl_erase, ctrl_wen, ctrl_start, done_flag, err_flag, irq, fl_we;
  logic [1:0] ctrl_msel;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  logic [7:0] mem [4096];
  logic [7:0] lat [BLK];
  logic [AW+7:0] expq [$];
  int checks = 0;
  int errors = 0;
  logic [AW-1:0] cur_ptr;

  always #4 clk = ~clk;

  frow_ctrl #(.ADDR_W(AW), .BLOCK(BLK), .FLASH_BYTES(3072), .PROT_BYTES(256),
              .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .busy(busy), .ctrl_msel(ctrl_msel),
    .ctrl_erase(ctrl_erase), .ctrl_wen(ctrl_wen), .ctrl_start(ctrl_start),
    .done_flag(done_flag), .err_flag(err_flag), .irq(irq), .fl_we(fl_we),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  assign fl_rdata = mem[fl_addr];
  always @(posedge clk) if (fl_we) mem[fl_addr] <= fl_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fl_we) begin
      if (expq.size() == 0) chk(1'b0, "R5/R6 unexpected flash write", int'(fl_addr), 0);
      else begin
        logic [AW+7:0] e;
        e = expq.pop_front();
        chk({fl_addr, fl_wdata} == e, "R3/R4 flash write", int'({fl_addr, fl_wdata}), int'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = s; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (s == 3'd2) lat[cur_ptr[2:0]] = d;
    if (s == 3'd0) cur_ptr[7:0] = d;
    if (s == 3'd1) cur_ptr[AW-1:8] = d[AW-9:0];
  endtask

  task automatic set_ptr(input logic [AW-1:0] a);
    wr(3'd0, a[7:0]);
    wr(3'd1, 8'(a[AW-1:8]));
  endtask

  task automatic push_row(input logic [AW-1:0] a, input bit erase);
    for (int i = 0; i < BLK; i++) begin
      logic [AW-1:0] ad;
      ad = {a[AW-1:3], 3'(i)};
      expq.push_back({ad, erase ? 8'hFF : (mem[ad] & lat[i])});
    end
  endtask

  task automatic unlock_start(input logic [7:0] c);
    wr(3'd4, 8'h55);
    wr(3'd4, 8'hAA);
    wr(3'd3, c);
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] c, input string req);
    int n;
    set_ptr(a);
    push_row(a, c[2]);
    unlock_start(c);
    n = 0;
    while (busy) begin
      if (cmd_ready) chk(1'b0, "R7 ready during busy", 1, 0);
      n++;
      @(negedge clk);
    end
    chk(n == BLK + OPC, "R7 busy length", n, BLK + OPC);
    chk(expq.size() == 0, {req, " all row bytes written"}, expq.size(), 0);
    chk(done_flag && !ctrl_start, "R8 done set, start cleared", {done_flag, ctrl_start}, 2);
    chk(ctrl_wen == 1'b1, "R8 wen unchanged", ctrl_wen, 1);
    if (!c[2]) for (int i = 0; i < BLK; i++) lat[i] = 8'hFF;
  endtask

  task automatic ignored(input string req);
    chk(!busy && !ctrl_start, {req, " start ignored"}, {busy, ctrl_start}, 0);
    repeat (3) @(negedge clk);
    chk(!busy, {req, " still idle"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < BLK; i++) lat[i] = 8'hFF;
    cur_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && cmd_ready && !ctrl_start && !ctrl_wen && !ctrl_erase, "R10 control idle",
        {busy, cmd_ready, ctrl_start, ctrl_wen, ctrl_erase}, 8);
    chk(!done_flag && !err_flag && !irq, "R10 flags clear", {done_flag, err_flag, irq}, 0);

    // R5: start without keys, with broken order, without write enable
    set_ptr(12'h200);
    wr(3'd3, 8'h1E);
    ignored("R5 no keys");
    wr(3'd4, 8'h55); wr(3'd5, 8'h00); wr(3'd4, 8'hAA); wr(3'd3, 8'h1E);
    ignored("R5 interleaved key");
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h0E); wr(3'd3, 8'h1E);
    ignored("R5 start not immediate");
    unlock_start(8'h16);
    ignored("R5 wen clear");

    // R4 erase
    run_op(12'h200, 8'h1E, "R4");
    for (int i = 0; i < BLK; i++) chk(mem[12'h200 + i] == 8'hFF, "R4 row is FF", mem[12'h200 + i], 8'hFF);
    chk(!irq, "R8 irq masked", irq, 0);
    wr(3'd5, 8'h01);
    chk(irq, "R8 irq enabled", irq, 1);

    // R1 latch loads leave done set
    set_ptr(12'h201); wr(3'd2, 8'h3C);
    set_ptr(12'h205); wr(3'd2, 8'hA5);
    chk(done_flag && !err_flag, "R1 flags untouched by latch write", {done_flag, err_flag}, 2);
    wr(3'd6, 8'h01);
    chk(!done_flag && !irq, "R9 done cleared", {done_flag, irq}, 0);

    // R3 partial program
    run_op(12'h200, 8'h1A, "R3");
    chk(mem[12'h201] == 8'h3C && mem[12'h205] == 8'hA5 && mem[12'h203] == 8'hFF,
        "R3 partial program", {mem[12'h201], mem[12'h205]}, 16'h3CA5);
    // R2/R3 latches reset, AND behaviour
    set_ptr(12'h201); wr(3'd2, 8'hF0);
    run_op(12'h200, 8'h1A, "R3");
    chk(mem[12'h201] == 8'h30 && mem[12'h205] == 8'hA5, "R2 R3 and with reset latches",
        {mem[12'h201], mem[12'h205]}, 16'h30A5);
    // R2 no latches loaded: row unchanged
    run_op(12'h300, 8'h1A, "R2");
    chk(mem[12'h303] == 8'(12'h303 * 7 + 3), "R2 row unchanged", mem[12'h303], 8'(12'h303 * 7 + 3));

    // R1 latch write in protected region, then program valid row
    set_ptr(12'h012); wr(3'd2, 8'h0F);
    chk(!err_flag, "R1 no protection check", err_flag, 0);
    run_op(12'h208, 8'h1A, "R1");
    chk(mem[12'h20A] == (8'(12'h20A * 7 + 3) & 8'h0F), "R1 latch index from pointer",
        mem[12'h20A], 8'(12'h20A * 7 + 3) & 8'h0F);

    // R6 rejections
    set_ptr(12'h010); unlock_start(8'h1A);
    chk(err_flag && !ctrl_start && !busy, "R6 protected", {err_flag, ctrl_start, busy}, 4);
    wr(3'd6, 8'h02);
    chk(!err_flag, "R9 err cleared", err_flag, 0);
    set_ptr(12'hC08); unlock_start(8'h1E);
    chk(err_flag && !busy, "R6 invalid address", {err_flag, busy}, 2);
    wr(3'd6, 8'h02);
    set_ptr(12'h210); unlock_start(8'h19);
    chk(err_flag && !busy, "R6 wrong memory select", {err_flag, busy}, 2);
    repeat (3) @(negedge clk);
    chk(mem[12'h210] == 8'(12'h210 * 7 + 3), "R6 no flash change", mem[12'h210], 8'(12'h210 * 7 + 3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule